// File: doc/BRIEF.md
# Single-Wire Byte Bus Master

This block is the master end of a single-wire bus of the kind used for battery fuel gauges. One open-drain data line carries every exchange. Software programs the block through a small byte-wide register bus and starts one of three transfers. A break pulse resets the slave. A byte transmit sends the transmit register out least significant bit first. A byte receive collects eight bits from the slave into the receive register.

A self-clearing GO bit in the control register starts each transfer. When the transfer ends, the block sets a sticky completion flag. Reading the flag register clears those flags. One interrupt request line reports any pending flag while the interrupt enable bit is set.

A soft reset returns every register to its reset value and aborts any transfer that is running. A status bit shows when the soft reset has finished. All waveform timings are parameters counted in clock ticks.

Top module: `swire_master`

## Requirements
- R1: Registers sit at these byte offsets: revision 0x00 (major number in bits 7:4, minor number in bits 3:0), transmit data 0x04 (reads back), receive data 0x08, control 0x0C, flags 0x10, system config 0x14, system status 0x18. After reset, control, flags, transmit and receive data all read 0, and system status reads 0x01. Control bits 0 (mode) and 5 (clock enable) are stored and read back, and they do not start a transfer.
- R2: Writing control with GO (bit 4) set, INIT (bit 2) clear and DIR (bit 1) clear sends the transmit byte, least significant bit first. Each bit occupies CELL_TICKS. At the start of each bit the line is driven low for ONE_LOW_TICKS if the bit is 1, or for ZERO_LOW_TICKS if the bit is 0, and is then released. At the end, flag bit 2 (transmit done) is set and GO reads 0.
- R3: Writing control with INIT and GO set starts a break, and INIT takes priority over DIR. The line is low for BRK_LOW_TICKS and then released for BRK_REC_TICKS. After that, flag bit 0 (timeout/break) is set and INIT and GO both read 0. DIR keeps the value that was written.
- R4: Writing control with DIR and GO set (INIT clear) receives a byte, and the master never drives the line. For each bit the block waits for a falling edge from the slave and samples the line SAMPLE_TICKS later. A low line gives a 0 and a high line gives a 1. Bits arrive least significant first. After eight bits the byte appears at offset 0x08, flag bit 1 (receive done) is set and GO reads 0.
- R5: During a receive, if no falling edge arrives within RX_WAIT_TICKS of entering the wait for a bit, the transfer stops. Flag bit 0 is set, flag bit 1 stays clear, GO reads 0 and the receive data register keeps its old value.
- R6: Reading offset 0x10 returns the flags and clears them in the same access. A flag that is set in the same cycle as the clearing read survives that read.
- R7: The irq output is 1 exactly while control bit 6 (interrupt enable) is 1 and any flag is set. GO and INIT clear at the end of a transfer even when interrupts are disabled.
- R8: While a transfer runs, a control write updates only bits 0, 5 and 6. Its GO, INIT and DIR bits are ignored and no second transfer starts.
- R9: Writing 1 to bit 1 of offset 0x14 aborts any transfer, releases the line and clears control, flags, transmit and receive data. For SRST_TICKS cycles after that write, offset 0x18 reads 0x00 and bit 1 of 0x14 reads 1. After that, 0x18 reads 0x01 and 0x14 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears flags at 0x10) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| lineIn | input | 1 | Level seen on the bus line |
| lineOe | output | 1 | 1 pulls the bus line low |
| irq | output | 1 | Interrupt request |

## Verification
The transmit path is driven with bytes of all zeros, all ones, alternating bits and mixed patterns. Measuring every low pulse and every cell spacing tells bit polarity and ordering apart from timing errors. The receive path uses the same variety of bytes, produced by a slave model with short and long low pulses, which tells a misplaced sample point from wrong bit assembly. Breaks are started with DIR also set, to confirm that INIT wins. Receives that get no slave reply tell the timeout outcome apart from a normal completion. A flag read timed to land on the same edge that sets the flag shows whether set beats clear.

// File: rtl/swire_pkg.sv
package swire_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_REV = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TXD = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RXD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLG = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_SCF = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SST = 5'h18;

  localparam int CTL_MODE = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_INIT = 2;
  localparam int CTL_GO   = 4;
  localparam int CTL_CKEN = 5;
  localparam int CTL_IE   = 6;
  localparam int SCF_SRST = 1;

  localparam int FLG_TMO = 0;
  localparam int FLG_RXC = 1;
  localparam int FLG_TXC = 2;

  typedef enum logic [1:0] {XF_TX, XF_RX, XF_BRK} xfer_e;

  // strobes from the sequencer to the register/datapath side
  typedef struct packed {
    logic shiftTx;
    logic shiftRx;
    logic rxBit;
    logic doneTx;
    logic doneRx;
    logic doneTmo;
  } strobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swire_dpath.sv
module swire_dpath
  import swire_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd0,
  parameter int SRST_TICKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  strobe_t           stb,
  input  logic              lineIn,
  output logic              lineLvl,
  output logic              lineFell,
  output logic              start,
  output xfer_e             startKind,
  output logic              txBit,
  output logic              busy,
  output logic              abort,
  output logic [2:0]        flags,
  output logic              irq
);
  localparam int SW = $clog2(SRST_TICKS + 1);

  logic [7:0] txReg, rxReg, txSh, rxSh;
  logic mode, dir, init, go, cken, ie;
  logic [2:0] flg;
  logic [SW-1:0] srstCnt;
  logic [2:0] syncQ;
  logic srstBusy, srstReq, ctlWr, flgRd;

  assign srstBusy = (srstCnt != '0);
  assign srstReq  = wrEn && (addr == OFS_SCF) && wrData[SCF_SRST];
  assign ctlWr    = wrEn && (addr == OFS_CTL) && !srstBusy;
  assign flgRd    = rdEn && (addr == OFS_FLG) && !srstBusy;
  assign start    = ctlWr && wrData[CTL_GO] && !go;
  assign startKind = wrData[CTL_INIT] ? XF_BRK : (wrData[CTL_DIR] ? XF_RX : XF_TX);
  assign abort    = srstReq || srstBusy;
  assign txBit    = txSh[0];
  assign busy     = go;
  assign flags    = flg;
  assign irq      = ie && (flg != '0);
  assign lineLvl  = syncQ[1];
  assign lineFell = syncQ[2] && !syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      srstCnt <= '0;
      txReg <= '0; rxReg <= '0; txSh <= '0; rxSh <= '0;
      mode <= 1'b0; dir <= 1'b0; init <= 1'b0; go <= 1'b0; cken <= 1'b0; ie <= 1'b0;
      flg <= '0;
    end else begin
      syncQ <= {syncQ[1:0], lineIn};
      if (srstReq || srstBusy) begin
        srstCnt <= srstReq ? SW'(SRST_TICKS) : srstCnt - 1'b1;
        txReg <= '0; rxReg <= '0; txSh <= '0; rxSh <= '0;
        mode <= 1'b0; dir <= 1'b0; init <= 1'b0; go <= 1'b0; cken <= 1'b0; ie <= 1'b0;
        flg <= '0;
      end else begin
        if (wrEn && addr == OFS_TXD) txReg <= wrData;
        if (ctlWr) begin
          mode <= wrData[CTL_MODE];
          cken <= wrData[CTL_CKEN];
          ie   <= wrData[CTL_IE];
          if (!go) begin
            dir  <= wrData[CTL_DIR];
            init <= wrData[CTL_INIT];
            go   <= wrData[CTL_GO];
          end
        end
        if (start) txSh <= txReg;
        else if (stb.shiftTx) txSh <= {1'b0, txSh[7:1]};
        if (stb.shiftRx) rxSh <= {stb.rxBit, rxSh[7:1]};
        if (stb.doneRx) rxReg <= {stb.rxBit, rxSh[7:1]};
        if (stb.doneTx || stb.doneRx || stb.doneTmo) go <= 1'b0;
        if (stb.doneTmo) init <= 1'b0;
        // a flag raised on the edge of a clearing read is kept
        flg <= (flg & ~{3{flgRd}}) | {stb.doneTx, stb.doneRx, stb.doneTmo};
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_REV: rdData = {REV_MAJOR, REV_MINOR};
      OFS_TXD: rdData = txReg;
      OFS_RXD: rdData = rxReg;
      OFS_CTL: rdData = {1'b0, ie, cken, go, 1'b0, init, dir, mode};
      OFS_FLG: rdData = {5'b0, flg};
      OFS_SCF: rdData = {6'b0, srstBusy, 1'b0};
      OFS_SST: rdData = {7'b0, !srstBusy};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int BRK_LOW_TICKS  = 19000,
  parameter int BRK_REC_TICKS  = 4000,
  parameter int CELL_TICKS     = 20000,
  parameter int ONE_LOW_TICKS  = 3000,
  parameter int ZERO_LOW_TICKS = 12000,
  parameter int RX_WAIT_TICKS  = 32000,
  parameter int SAMPLE_TICKS   = 6500
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    softRst,
  input  logic    start,
  input  xfer_e   startKind,
  input  logic    txBit,
  input  logic    lineLvl,
  input  logic    lineFell,
  output strobe_t stb,
  output logic    lineOe
);
  localparam int CMAX = maxOf(maxOf(maxOf(BRK_LOW_TICKS, BRK_REC_TICKS),
                                    maxOf(CELL_TICKS, RX_WAIT_TICKS)), SAMPLE_TICKS);
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_BLOW, S_BREC, S_TLOW, S_THIGH, S_RWAIT, S_RSAMP} st_e;

  st_e st, stN;
  logic [CW-1:0] cnt, cntN, lowLen;
  logic [2:0] bitIdx, bitN;

  assign lowLen = txBit ? CW'(ONE_LOW_TICKS) : CW'(ZERO_LOW_TICKS);

  always_comb begin
    stN  = st;
    cntN = cnt + 1'b1;
    bitN = bitIdx;
    stb  = '0;
    case (st)
      S_IDLE: begin
        cntN = '0;
        bitN = '0;
        if (start) begin
          case (startKind)
            XF_BRK:  stN = S_BLOW;
            XF_RX:   stN = S_RWAIT;
            default: stN = S_TLOW;
          endcase
        end
      end
      S_BLOW: if (cnt == CW'(BRK_LOW_TICKS - 1)) begin stN = S_BREC; cntN = '0; end
      S_BREC: if (cnt == CW'(BRK_REC_TICKS - 1)) begin stN = S_IDLE; stb.doneTmo = 1'b1; end
      S_TLOW: if (cnt == lowLen - 1'b1) stN = S_THIGH;
      S_THIGH: begin
        if (cnt == CW'(CELL_TICKS - 1)) begin
          cntN = '0;
          if (bitIdx == 3'd7) begin
            stN = S_IDLE;
            stb.doneTx = 1'b1;
          end else begin
            stN = S_TLOW;
            bitN = bitIdx + 1'b1;
            stb.shiftTx = 1'b1;
          end
        end
      end
      S_RWAIT: begin
        if (lineFell) begin
          stN = S_RSAMP;
          cntN = '0;
        end else if (cnt == CW'(RX_WAIT_TICKS - 1)) begin
          stN = S_IDLE;
          stb.doneTmo = 1'b1;
        end
      end
      S_RSAMP: begin
        if (cnt == CW'(SAMPLE_TICKS - 1)) begin
          cntN = '0;
          stb.rxBit = lineLvl;
          if (bitIdx == 3'd7) begin
            stN = S_IDLE;
            stb.doneRx = 1'b1;
          end else begin
            stN = S_RWAIT;
            bitN = bitIdx + 1'b1;
            stb.shiftRx = 1'b1;
          end
        end
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; cnt <= '0; bitIdx <= '0; lineOe <= 1'b0;
    end else if (softRst) begin
      st <= S_IDLE; cnt <= '0; bitIdx <= '0; lineOe <= 1'b0;
    end else begin
      st <= stN;
      cnt <= cntN;
      bitIdx <= bitN;
      lineOe <= (stN == S_BLOW) || (stN == S_TLOW);
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd0,
  parameter int SRST_TICKS     = 16,
  parameter int BRK_LOW_TICKS  = 19000,
  parameter int BRK_REC_TICKS  = 4000,
  parameter int CELL_TICKS     = 20000,
  parameter int ONE_LOW_TICKS  = 3000,
  parameter int ZERO_LOW_TICKS = 12000,
  parameter int RX_WAIT_TICKS  = 32000,
  parameter int SAMPLE_TICKS   = 6500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       lineIn,
  output logic       lineOe,
  output logic       irq
);
  strobe_t stb;
  xfer_e startKind;
  logic start, txBit, lineLvl, lineFell, busy, abort;
  logic [2:0] flags;

  swire_dpath #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .SRST_TICKS(SRST_TICKS)) u_dpath (
    .clk(clk), .rstN(rstN), .addr(regAddr), .wrEn(regWr), .rdEn(regRd),
    .wrData(regWrData), .rdData(regRdData), .stb(stb), .lineIn(lineIn),
    .lineLvl(lineLvl), .lineFell(lineFell), .start(start), .startKind(startKind),
    .txBit(txBit), .busy(busy), .abort(abort), .flags(flags), .irq(irq)
  );

  swire_ctrl #(
    .BRK_LOW_TICKS(BRK_LOW_TICKS), .BRK_REC_TICKS(BRK_REC_TICKS), .CELL_TICKS(CELL_TICKS),
    .ONE_LOW_TICKS(ONE_LOW_TICKS), .ZERO_LOW_TICKS(ZERO_LOW_TICKS),
    .RX_WAIT_TICKS(RX_WAIT_TICKS), .SAMPLE_TICKS(SAMPLE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(abort), .start(start), .startKind(startKind),
    .txBit(txBit), .lineLvl(lineLvl), .lineFell(lineFell), .stb(stb), .lineOe(lineOe)
  );
endmodule

// File: rtl/swire_checker.sv
module swire_checker
  import swire_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       lineOe,
  input logic       busy,
  input logic       abort,
  input strobe_t    stb,
  input logic [2:0] flags
);
  // R2, R3: the line is only pulled while a transfer owns it
  a_r2_drive_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> busy);
  // R2: transmit-done flag only rises after a transmit completion
  a_r2_txflag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_TXC]) |-> $past(stb.doneTx));
  // R4: receive-done flag only rises after a receive completion
  a_r4_rxflag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_RXC]) |-> $past(stb.doneRx));
  // R3, R5: timeout flag only rises after a break end or a missed reply
  a_r5_tmoflag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_TMO]) |-> $past(stb.doneTmo));
  // R7: GO drops after any completion, independent of interrupt enable
  a_r7_go_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doneTx || stb.doneRx || stb.doneTmo) |=> !busy);
  // R9: soft reset releases the line and ends the transfer
  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!lineOe && !busy));
  // R8: GO never drops without a completion or an abort
  a_r8_go_holds: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(stb.doneTx || stb.doneRx || stb.doneTmo || abort));
endmodule

bind swire_master swire_checker u_chk (
  .clk(clk), .rstN(rstN), .lineOe(lineOe), .busy(busy),
  .abort(abort), .stb(stb), .flags(flags)
);

// File: tb/swire_master_bench.sv
module swire_master_bench;
  localparam int P_BLOW = 30, P_BREC = 10, P_CELL = 20, P_ONE = 4, P_ZERO = 12;
  localparam int P_RWAIT = 60, P_SAMP = 12, P_SRST = 5;
  localparam logic [4:0] A_REV = 5'h00, A_TXD = 5'h04, A_RXD = 5'h08, A_CTL = 5'h0C;
  localparam logic [4:0] A_FLG = 5'h10, A_SCF = 5'h14, A_SST = 5'h18;
  // bit 8: 1 = receive vector, 0 = transmit vector; bits 7:0 = byte
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h000, 9'h1FF, 9'h13C, 9'h0FF, 9'h181};

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWrData = '0, regRdData, rdv, lastRx;
  logic lineIn, lineOe, irq;
  logic slaveLow = 1'b0, inRx = 1'b0;
  int nChecks = 0, nErrs = 0, oeInRx = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign lineIn = !(lineOe || slaveLow);

  swire_master #(
    .REV_MAJOR(4'd3), .REV_MINOR(4'd1), .SRST_TICKS(P_SRST),
    .BRK_LOW_TICKS(P_BLOW), .BRK_REC_TICKS(P_BREC), .CELL_TICKS(P_CELL),
    .ONE_LOW_TICKS(P_ONE), .ZERO_LOW_TICKS(P_ZERO),
    .RX_WAIT_TICKS(P_RWAIT), .SAMPLE_TICKS(P_SAMP)
  ) u_swire_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .lineIn(lineIn),
    .lineOe(lineOe), .irq(irq)
  );

  always @(negedge clk) if (inRx && lineOe) oeInRx++;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [4:0] a);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 rdv = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTx(logic [7:0] b);
    int t = 0, w = 0, nb = 0, badW = 0, badCell = 0;
    int rise [8];
    logic prev = 1'b0;
    logic [7:0] got = '0;
    regWrite(A_TXD, b);
    regWrite(A_CTL, 8'h10);
    repeat (8 * P_CELL + 3) begin
      if (lineOe) begin
        if (!prev) begin
          if (nb < 8) rise[nb] = t;
          w = 0;
        end
        w++;
      end else if (prev) begin
        if (nb < 8) got[nb] = (w == P_ONE);
        if (w != P_ONE && w != P_ZERO) badW++;
        nb++;
      end
      prev = lineOe;
      t++;
      @(negedge clk);
    end
    for (int i = 1; i < 8; i++) if (rise[i] - rise[i-1] != P_CELL) badCell++;
    check("R2 bit count", nb, 8);
    check("R2 byte LSB first", int'(got), int'(b));
    check("R2 low widths", badW, 0);
    check("R2 cell spacing", badCell, 0);
    regRead(A_FLG); check("R2 txdone flag", int'(rdv), 8'h04);
    regRead(A_CTL); check("R2 GO cleared", int'(rdv), 8'h00);
  endtask

  task automatic doRx(logic [7:0] b);
    regWrite(A_CTL, 8'h12);
    inRx = 1'b1;
    for (int i = 0; i < 8; i++) begin
      idle(5);
      slaveLow = 1'b1;
      idle(b[i] ? 4 : 24);
      slaveLow = 1'b0;
      idle(b[i] ? 31 : 11);
    end
    idle(5);
    inRx = 1'b0;
    check("R4 master silent", oeInRx, 0);
    regRead(A_FLG); check("R4 rxdone flag", int'(rdv), 8'h02);
    regRead(A_RXD); check("R4 rx byte", int'(rdv), int'(b));
    regRead(A_CTL); check("R4 GO cleared", int'(rdv), 8'h02);
    lastRx = b;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nErrs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    int w;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state and map
    regRead(A_REV); check("R1 revision", int'(rdv), 8'h31);
    regRead(A_CTL); check("R1 ctrl reset", int'(rdv), 8'h00);
    regRead(A_FLG); check("R1 flags reset", int'(rdv), 8'h00);
    regRead(A_SST); check("R1 status reset", int'(rdv), 8'h01);
    regRead(A_RXD); check("R1 rx reset", int'(rdv), 8'h00);
    check("R1 line idle", int'(lineOe), 0);
    check("R1 irq idle", int'(irq), 0);
    regWrite(A_TXD, 8'hC3);
    regRead(A_TXD); check("R1 tx readback", int'(rdv), 8'hC3);
    regWrite(A_CTL, 8'h21);
    regRead(A_CTL); check("R1 mode/cken readback", int'(rdv), 8'h21);
    idle(4);
    check("R1 no transfer from mode bits", int'(lineOe), 0);
    regWrite(A_CTL, 8'h00);

    // vector table: R2 transmit and R4 receive
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][8]) doRx(VEC[v][7:0]);
      else doTx(VEC[v][7:0]);
    end

    // R5 receive without a reply
    regWrite(A_CTL, 8'h12);
    idle(P_RWAIT + 5);
    regRead(A_FLG); check("R5 timeout flag only", int'(rdv), 8'h01);
    regRead(A_RXD); check("R5 rx data kept", int'(rdv), int'(lastRx));
    regRead(A_CTL); check("R5 GO cleared", int'(rdv), 8'h02);

    // R3 break with DIR also set, interrupts on
    regWrite(A_CTL, 8'h56);
    w = 0;
    while (lineOe && w < 1000) begin w++; @(negedge clk); end
    check("R3 break low width", w, P_BLOW);
    regRead(A_CTL); check("R3 ctrl during recovery", int'(rdv), 8'h56);
    check("R7 irq low before flag", int'(irq), 0);
    idle(P_BREC + 2);
    check("R7 irq with enable", int'(irq), 1);
    regRead(A_CTL); check("R3 INIT and GO cleared", int'(rdv), 8'h42);
    regRead(A_FLG); check("R3 timeout flag", int'(rdv), 8'h01);
    check("R7 irq drops after clear", int'(irq), 0);

    // R6 read lands on the edge that sets the flag; R7 interrupts off
    regWrite(A_CTL, 8'h14);
    idle(P_BLOW + P_BREC - 2);
    regRead(A_FLG); check("R6 coincident read sees old", int'(rdv), 8'h00);
    check("R7 irq off without enable", int'(irq), 0);
    regRead(A_FLG); check("R6 flag survives", int'(rdv), 8'h01);
    regRead(A_FLG); check("R6 flag cleared by read", int'(rdv), 8'h00);
    regRead(A_CTL); check("R7 GO/INIT clear without irq", int'(rdv), 8'h00);

    // R8 control write during a transmit
    regWrite(A_TXD, 8'h96);
    regWrite(A_CTL, 8'h10);
    idle(10);
    regWrite(A_CTL, 8'h56);
    regRead(A_CTL); check("R8 only low-risk bits change", int'(rdv), 8'h50);
    idle(8 * P_CELL);
    check("R8 irq from enable bit", int'(irq), 1);
    regRead(A_FLG); check("R8 still a transmit", int'(rdv), 8'h04);
    regRead(A_CTL); check("R8 end state", int'(rdv), 8'h40);

    // R9 soft reset mid transfer
    regWrite(A_TXD, 8'h5A);
    regWrite(A_CTL, 8'h50);
    idle(6);
    regWrite(A_SCF, 8'h02);
    check("R9 line released", int'(lineOe), 0);
    regRead(A_SST); check("R9 not done", int'(rdv), 8'h00);
    regRead(A_SCF); check("R9 in progress", int'(rdv), 8'h02);
    idle(P_SRST);
    regRead(A_SST); check("R9 done", int'(rdv), 8'h01);
    regRead(A_SCF); check("R9 progress clear", int'(rdv), 8'h00);
    regRead(A_CTL); check("R9 ctrl cleared", int'(rdv), 8'h00);
    regRead(A_TXD); check("R9 tx cleared", int'(rdv), 8'h00);
    regRead(A_RXD); check("R9 rx cleared", int'(rdv), 8'h00);
    regRead(A_FLG); check("R9 flags cleared", int'(rdv), 8'h00);
    check("R9 irq low", int'(irq), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule